// File: doc/BRIEF.md
# Multicycle Five-Phase RISC Sequencer

This block is a small processor core that does not overlap instructions. Every instruction passes through five phases, one clock each, in a fixed order: fetch, decode with register read, execute or address calculation, memory access or branch completion, and writeback. Each value produced along the way is held in its own register: the instruction word, the incremented PC, the two source operands, the extended immediate, the execute result, the condition flag and the loaded word. A single adder and logic unit serves register-register arithmetic, address calculation and branch-target calculation.

The core drives one memory port that carries both instruction fetches and data accesses. It presents the address and write data from its registers. The memory must return read data for the presented address in the same cycle, and it must commit a write at the clock edge that ends a cycle in which the write enable is high. Instructions that have nothing to write back leave out the last phase: stores, both conditional branches and the jump finish in four cycles, and every other instruction finishes in five. A retire pulse and a free-running cycle counter make these per-class cycle counts visible, so cycles per instruction can be measured from outside.

Instruction word layouts use bits [31:26] as the opcode in every form. The I form holds a source register at [25:21], a second register (the destination, or the store data source) at [20:16] and a signed 16-bit immediate at [15:0]. The register-register form has opcode 0, the sources at [25:21] and [20:16], the destination at [15:11] and a function code at [5:0]. The jump form holds a signed 26-bit offset at [25:0].

Top module: `mcyc_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the core is in fetch with PC 0, so the first fetch address is 0. Every fetch latches the word and forms next-PC = PC + 4. Phases follow one another in order, one clock each.
- R2: Opcode 0x00 with function 0x20 (add), 0x22 (subtract), 0x24 (and) or 0x25 (or) writes rs1 op rs2 to register [15:11] and takes 5 cycles.
- R3: Register 0 always reads as zero, and any write to it is discarded.
- R4: Opcode 0x23 (load word) reads memory at rs1 + sign-extended imm16 and writes the word to register [20:16] in writeback. It takes 5 cycles.
- R5: Opcode 0x2B (store word) writes register [20:16] to memory at rs1 + sign-extended imm16 in the memory phase. It writes no register and takes 4 cycles.
- R6: Opcode 0x04 (branch if zero) sets the PC to next-PC + sign-extended imm16 when rs1 equals zero, and otherwise to next-PC. It takes 4 cycles.
- R7: Opcode 0x05 (branch if not zero) takes the same target when rs1 is non-zero, and otherwise falls through. It takes 4 cycles.
- R8: Opcode 0x02 (jump) always sets the PC to next-PC + sign-extended 26-bit offset. It takes 4 cycles.
- R9: The retire output is high for exactly one cycle, the first cycle after each instruction completes. The cycle counter starts at 0 when reset is released and rises by one on every clock.
- R10: The memory write enable is high only in the memory phase of a store.
- R11: Any other opcode changes no register, no memory word and no control flow (the PC moves to next-PC). It takes 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address: the PC in fetch, the execute result otherwise |
| mem_rdata | input | 32 | Read data for mem_addr, valid in the same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Store data |
| retire | output | 1 | One-cycle pulse after each completed instruction |
| cycle_cnt | output | 32 | Free-running cycle count since reset |

## Verification
The hardest case to observe from the ports is an instruction that must have no effect. Examples are a write aimed at register 0, the instructions skipped over by a taken branch or jump, and an unrecognised opcode. None of these shows up at the memory port on its own. The program therefore runs each of them and then stores the affected registers, and it places stores in the shadow of every taken branch and of the jump. If any of those stores executes, it writes into a memory word that must stay zero. The behavioural model predicts the fetch address, the retire timing and every store for each cycle, so a wrong target or a wrong phase count shows up in the very cycle it occurs.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam logic [5:0] OPC_RR  = 6'h00;
  localparam logic [5:0] OPC_J   = 6'h02;
  localparam logic [5:0] OPC_BZ  = 6'h04;
  localparam logic [5:0] OPC_BNZ = 6'h05;
  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_SW  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [2:0] {PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB} phase_t;
  typedef enum logic [1:0] {AL_ADD, AL_SUB, AL_AND, AL_OR} alu_op_t;
endpackage

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_t        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N),
  localparam int NRD = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [NRD-1:0][AW-1:0]  ra,
  output logic [NRD-1:0][W-1:0]   q,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [W-1:0]            wd
);
  logic [W-1:0] bank [N];

  // write port: entry 0 is never written
  always_ff @(posedge clk) begin
    if (we && wa != '0) bank[wa] <= wd;
  end

  // registered read ports double as the operand holding registers
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (rd_en) q[g] <= (ra[g] == '0) ? '0 : bank[ra[g]];
    end

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
      (rd_en && ra[g] == '0) |=> (q[g] == '0)); // R3
  end
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  mem_addr,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             retire,
  output logic [CNT_W-1:0] cycle_cnt
);
  localparam int RF_AW  = 5;
  localparam int NREG   = 1 << RF_AW;
  localparam int IMM_S  = 16;
  localparam int IMM_L  = 26;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  phase_t           phase;
  logic [XLEN-1:0]  pc, npc, ir, imm, alu_q, lmd;
  logic [XLEN-1:0]  a_q, b_q;
  logic             cond;
  logic             retire_q;
  logic [CNT_W-1:0] cnt_q;

  // decode of the held instruction word
  logic [5:0] opc, fn;
  logic is_rr, rr_ok, is_lw, is_sw, is_bz, is_bnz, is_j, is_ctl, is_short;
  alu_op_t rr_op, alu_sel;

  assign opc      = ir[31:26];
  assign fn       = ir[5:0];
  assign is_rr    = (opc == OPC_RR);
  assign rr_ok    = is_rr && (fn == FN_ADD || fn == FN_SUB || fn == FN_AND || fn == FN_OR);
  assign is_lw    = (opc == OPC_LW);
  assign is_sw    = (opc == OPC_SW);
  assign is_bz    = (opc == OPC_BZ);
  assign is_bnz   = (opc == OPC_BNZ);
  assign is_j     = (opc == OPC_J);
  assign is_ctl   = is_bz || is_bnz || is_j;
  assign is_short = is_sw || is_ctl;

  always_comb begin
    case (fn)
      FN_SUB:  rr_op = AL_SUB;
      FN_AND:  rr_op = AL_AND;
      FN_OR:   rr_op = AL_OR;
      default: rr_op = AL_ADD;
    endcase
  end

  // one shared adder/logic unit for results, addresses and targets
  logic [XLEN-1:0] opa, opb, alu_y;
  assign opa     = is_ctl ? npc : a_q;
  assign opb     = is_rr  ? b_q : imm;
  assign alu_sel = is_rr  ? rr_op : AL_ADD;

  mcyc_alu #(.W(XLEN)) u_alu (
    .op (alu_sel),
    .a  (opa),
    .b  (opb),
    .y  (alu_y)
  );

  // register file: read in decode, write in writeback
  logic [1:0][RF_AW-1:0] rf_ra;
  logic [1:0][XLEN-1:0]  rf_q;
  logic                  rf_we;
  logic [RF_AW-1:0]      rf_wa;
  logic [XLEN-1:0]       rf_wd;

  assign rf_ra[0] = ir[25:21];
  assign rf_ra[1] = ir[20:16];
  assign a_q      = rf_q[0];
  assign b_q      = rf_q[1];
  assign rf_we    = (phase == PH_WB) && (rr_ok || is_lw);
  assign rf_wa    = is_lw ? ir[20:16] : ir[15:11];
  assign rf_wd    = is_lw ? lmd : alu_q;

  mcyc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .rd_en (phase == PH_ID),
    .ra    (rf_ra),
    .q     (rf_q),
    .we    (rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // phase sequencer and holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IF;
      pc       <= '0;
      npc      <= '0;
      ir       <= '0;
      imm      <= '0;
      alu_q    <= '0;
      lmd      <= '0;
      cond     <= 1'b0;
      retire_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      retire_q <= 1'b0;
      case (phase)
        PH_IF: begin
          ir    <= mem_rdata;
          npc   <= pc + WORD_BYTES;
          phase <= PH_ID;
        end
        PH_ID: begin
          imm   <= is_j ? {{(XLEN-IMM_L){ir[IMM_L-1]}}, ir[IMM_L-1:0]}
                        : {{(XLEN-IMM_S){ir[IMM_S-1]}}, ir[IMM_S-1:0]};
          phase <= PH_EX;
        end
        PH_EX: begin
          alu_q <= alu_y;
          cond  <= is_j || (is_bz && a_q == '0) || (is_bnz && a_q != '0);
          phase <= PH_MEM;
        end
        PH_MEM: begin
          if (is_lw) lmd <= mem_rdata;
          pc <= cond ? alu_q : npc;
          if (is_short) begin
            phase    <= PH_IF;
            retire_q <= 1'b1;
          end else begin
            phase <= PH_WB;
          end
        end
        PH_WB: begin
          phase    <= PH_IF;
          retire_q <= 1'b1;
        end
        default: phase <= PH_IF;
      endcase
    end
  end

  assign mem_addr  = (phase == PH_IF) ? pc : alu_q;
  assign mem_we    = (phase == PH_MEM) && is_sw;
  assign mem_wdata = b_q;
  assign retire    = retire_q;
  assign cycle_cnt = cnt_q;

  AST_NPC_IS_PC_PLUS4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ID) |-> (npc == pc + WORD_BYTES)); // R1
  AST_PC_ONLY_IN_MEM: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_MEM) |=> $stable(pc)); // R6
  AST_NO_WB_FOR_SHORT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WB) |-> !is_short); // R5
  AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire); // R9
  AST_RETIRE_AT_FETCH: assert property (@(posedge clk) disable iff (rst)
    retire |-> (phase == PH_IF)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cycle_cnt == $past(cycle_cnt) + 1'b1)); // R9
  AST_WRITE_AFTER_EX: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(phase) == PH_EX)); // R10
endmodule

// File: tb/sim_mcyc_core.sv
module sim_mcyc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, mem_wdata, cycle_cnt;
  logic        mem_we, retire;

  always #5 clk = ~clk;

  mcyc_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .retire(retire), .cycle_cnt(cycle_cnt)
  );

  // shared instruction/data memory, 256 words
  logic [31:0] mem  [256];
  logic [31:0] mmem [256];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int im);
    return {op, 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_j(input int off);
    return {6'h02, 26'(off)};
  endfunction

  // reference model state
  logic [31:0] rf [32];
  logic [31:0] mpc, exp_cnt, sa, sd;
  int ph, lat;
  bit exp_ret, is_store;
  string ctag, ptag;

  task automatic model_issue();
    logic [31:0] ins, nxt, x, y, s16, s26, ea;
    ins = mmem[mpc[9:2]];
    nxt = mpc + 32'd4;
    s16 = {{16{ins[15]}}, ins[15:0]};
    s26 = {{6{ins[25]}}, ins[25:0]};
    x   = rf[ins[25:21]];
    y   = rf[ins[20:16]];
    lat = 5; is_store = 1'b0;
    case (ins[31:26])
      6'h00: begin
        ctag = "R2";
        case (ins[5:0])
          6'h20: rf[ins[15:11]] = x + y;
          6'h22: rf[ins[15:11]] = x - y;
          6'h24: rf[ins[15:11]] = x & y;
          6'h25: rf[ins[15:11]] = x | y;
          default: ;
        endcase
      end
      6'h23: begin ctag = "R4"; ea = x + s16; rf[ins[20:16]] = mmem[ea[9:2]]; end
      6'h2B: begin
        ctag = "R5"; lat = 4; is_store = 1'b1;
        sa = x + s16; sd = y; mmem[sa[9:2]] = sd;
      end
      6'h04: begin ctag = "R6"; lat = 4; if (x == 0) nxt = nxt + s16; end
      6'h05: begin ctag = "R7"; lat = 4; if (x != 0) nxt = nxt + s16; end
      6'h02: begin ctag = "R8"; lat = 4; nxt = nxt + s26; end
      default: ctag = "R11";
    endcase
    rf[0] = 32'd0; // R3
    mpc = nxt;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) rf[i] = 32'd0;
    mem[0]  = enc_i(6'h23, 0, 1, 32'h200);
    mem[1]  = enc_i(6'h23, 0, 2, 32'h204);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(1, 2, 5, 6'h24);
    mem[5]  = enc_r(1, 2, 6, 6'h25);
    mem[6]  = enc_r(1, 1, 0, 6'h20);          // write to r0
    mem[7]  = enc_i(6'h2B, 0, 3, 32'h280);
    mem[8]  = enc_i(6'h2B, 0, 4, 32'h284);
    mem[9]  = enc_i(6'h2B, 0, 5, 32'h288);
    mem[10] = enc_i(6'h2B, 0, 6, 32'h28C);
    mem[11] = enc_i(6'h2B, 0, 0, 32'h290);
    mem[12] = enc_i(6'h04, 0, 0, 4);          // taken
    mem[13] = enc_i(6'h2B, 0, 1, 32'h294);    // shadow
    mem[14] = enc_i(6'h05, 0, 0, 4);          // not taken
    mem[15] = enc_i(6'h05, 1, 0, 8);          // taken
    mem[16] = enc_i(6'h2B, 0, 1, 32'h298);
    mem[17] = enc_i(6'h2B, 0, 1, 32'h298);
    mem[18] = enc_i(6'h04, 1, 0, 4);          // not taken
    mem[19] = enc_i(6'h23, 0, 9, 32'h208);
    mem[20] = enc_i(6'h2B, 9, 1, -4);         // negative offset
    mem[21] = enc_j(8);
    mem[22] = enc_i(6'h2B, 0, 2, 32'h2A8);
    mem[23] = enc_i(6'h2B, 0, 2, 32'h2A8);
    mem[24] = {6'h3F, 5'd1, 5'd2, 16'd0};     // unknown opcode
    mem[25] = enc_i(6'h2B, 0, 2, 32'h2AC);
    mem[26] = enc_i(6'h23, 0, 10, 32'h280);   // load after store
    mem[27] = enc_i(6'h2B, 0, 10, 32'h2B0);
    mem[28] = enc_j(-4);                       // self loop
    mem[128] = 32'd7;
    mem[129] = 32'hFFFF_FFFD;
    mem[130] = 32'h0000_02A4;
    for (int i = 0; i < 256; i++) mmem[i] = mem[i];

    mpc = 32'd0; exp_cnt = 32'd0; ph = 0; lat = 5; exp_ret = 1'b0;
    ctag = "R1"; ptag = "R1";

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset cycle count", cycle_cnt, 32'd0);
    chk("R1 reset retire", {31'd0, retire}, 32'd0);

    for (int cyc = 0; cyc < 400; cyc++) begin
      chk("R9 cycle count", cycle_cnt, exp_cnt);
      chk({"R9 retire after ", ptag}, {31'd0, retire}, {31'd0, exp_ret});
      if (ph == 0) begin
        chk({"R1 fetch address after ", ptag}, mem_addr, mpc);
        model_issue();
      end
      if (ph == 3 && is_store) begin
        chk("R5 store enable", {31'd0, mem_we}, 32'd1);
        chk("R5 store address", mem_addr, sa);
        chk("R5 store data", mem_wdata, sd);
      end else begin
        chk({"R10 no write during ", ctag}, {31'd0, mem_we}, 32'd0);
      end
      exp_cnt = exp_cnt + 32'd1;
      ph++;
      exp_ret = (ph == lat);
      if (exp_ret) begin ph = 0; ptag = ctag; end
      @(negedge clk);
    end

    chk("R2 add result", mem[160], 32'd4);
    chk("R2 sub result", mem[161], 32'd10);
    chk("R2 and result", mem[162], 32'd5);
    chk("R2 or result", mem[163], 32'hFFFF_FFFF);
    chk("R3 r0 after write", mem[164], 32'd0);
    chk("R6 shadow store skipped", mem[165], 32'd0);
    chk("R7 shadow store skipped", mem[166], 32'd0);
    chk("R4 negative offset store", mem[168], 32'd7);
    chk("R8 jump shadow skipped", mem[170], 32'd0);
    chk("R11 unknown opcode left r2", mem[171], 32'hFFFF_FFFD);
    chk("R4 load after store", mem[172], 32'd4);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule